// File: doc/BRIEF.md
# NAND Flash Page Operation Sequencer

This block drives one 8-bit raw NAND flash device through a complete operation each time the host makes a request. The operations are page read, page program, block erase, read-ID, device reset, status read, and the two random-access forms: a column jump inside an already loaded page, and column-addressed data input. The host gives an operation code, a 16-bit page (row) address, a 12-bit column address and a transfer length. The sequencer then emits each framing phase in turn: the command byte, the address bytes, the data stream, the confirming command, the busy wait and the status poll. It releases the device when the operation is complete.

Each bus cycle lasts three clocks: setup, strobe low, then strobe high. Data bytes move through two byte-wide valid/ready streams, one towards the device and one towards the host. Busy waits watch a sticky record of R/B# rising edges, and a parameterised timeout bounds every wait. Each operation ends with a one-cycle `done` pulse, and `fail` reports its result.

Top module: `nand_page_seq`

## Requirements
- R1: A request is taken only while `req_ready` is high, which happens only when the block is idle. CE# goes low on the clock edge that takes the request and stays low for the whole operation. CE# is high during the `done` cycle and while idle.
- R2: The address goes out in this order: column bits 7:0, then column bits 11:8 (upper nibble zero), then row bits 7:0, then row bits 15:8. Operations that send only a column or only a row send just that pair.
- R3: Page read is op 0. It sends command 0x00, four address bytes and command 0x30. It then waits for R/B# to rise and reads `req_len`+1 bytes onto the host stream.
- R4: Page program is op 1. It sends 0x80, four address bytes, `req_len`+1 bytes from the host stream and 0x10. It then sends 0x70 and reads status bytes until bit 6 is set. `fail` equals bit 0 of that last status byte.
- R5: Block erase is op 2. It sends 0x60, the two row bytes and 0xD0, then polls status exactly as R4 does.
- R6: Read-ID is op 3. It sends 0x90 and one address byte of 0x00, then passes five bytes to the host.
- R7: Reset is op 4. It sends 0xFF and then waits for R/B# to rise. Status read is op 5. It sends 0x70 and passes one byte to the host.
- R8: Random read is op 6. It sends 0x05, two column bytes and 0xE0, then reads `req_len`+1 bytes with no busy wait. Random data input is op 7. It sends 0x85 and two column bytes, streams `req_len`+1 bytes, sends 0x10 and polls status as R4 does.
- R9: A rising edge of R/B# that comes before the busy-causing command never ends the busy wait. No read strobe appears while R/B# is low after 0x30.
- R10: If R/B# has not risen after `TMO_CYCLES` clocks in a busy wait, the operation ends with `fail`=1. The `done` pulse comes `TMO_CYCLES`+1 clocks after the strobe of the busy-causing command ends.
- R11: `done` is high for exactly one clock. CLE and ALE are never high together.
- R12: While `rd_ready` is low, `rd_valid` stays high and `rd_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | High when idle and able to take a request |
| req_op | input | 3 | Operation code (see R3 to R8) |
| req_row | input | 16 | Page address |
| req_col | input | 12 | Column address |
| req_len | input | 12 | Byte count minus one for data transfers |
| wr_data | input | 8 | Byte to program |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write byte taken on this edge |
| rd_data | output | 8 | Byte read from the device |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Host takes the read byte |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | Result of the last operation |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Bus value driven to the device |
| nf_io_oe | output | 1 | Bus output enable |
| nf_io_in | input | 8 | Bus value from the device |
| nf_rb | input | 1 | Ready/busy, low while busy |

## Verification
CE# is due low one clock after the request is taken, and the bench samples it at the falling edge that follows. A device byte is captured on the clock edge that ends the read strobe, so the bench's device model sets the bus at the falling edge inside the strobe-low clock. The timeout `done` is due exactly `TMO_CYCLES`+1 clocks after the busy command's strobe rises. The bench counts falling edges between those two events in one process and compares the count with that exact figure. The `done` pulse is checked for width on the following falling edge, and every bus cycle is logged at the falling edge after WE# rises, when CLE, ALE and the bus still hold their values.

// File: rtl/nand_page_seq.sv
module nand_page_seq #(
  parameter int TMO_CYCLES = 1_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [15:0] req_row,
  input  logic [11:0] req_col,
  input  logic [11:0] req_len,
  input  logic [7:0]  wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic        done,
  output logic        fail,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_io_out,
  output logic        nf_io_oe,
  input  logic [7:0]  nf_io_in,
  input  logic        nf_rb
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYCLES - 1);
  localparam logic [2:0] OP_READ = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2, OP_ID = 3'd3,
                         OP_RST  = 3'd4, OP_STAT = 3'd5, OP_RRD   = 3'd6, OP_RIN = 3'd7;

  typedef enum logic [3:0] {S_IDLE, S_CMD1, S_ADDR, S_DOUT, S_CMD2, S_WAIT,
                            S_DIN, S_STCMD, S_STRD, S_FIN} st_t;

  st_t         st, nxt_cmd1, nxt_addr, nxt_cmd2;
  logic [1:0]  ph;
  logic [2:0]  op;
  logic [15:0] row;
  logic [11:0] col, len, cnt, addr_first, addr_last, din_last;
  logic [TW-1:0] tmo;
  logic [7:0]  dbyte, cmd1_b, cmd2_b, addr_b;
  logic        rb_q, rb_seen, st_rdy, st_bad, go, clr_seen;

  always_comb begin
    cmd1_b = 8'h00; cmd2_b = 8'h10; nxt_cmd1 = S_ADDR; nxt_addr = S_CMD2; nxt_cmd2 = S_STCMD;
    addr_first = 12'd0; addr_last = 12'd3; din_last = len;
    case (op)
      OP_READ:  begin cmd1_b = 8'h00; cmd2_b = 8'h30; nxt_cmd2 = S_WAIT; end
      OP_PROG:  begin cmd1_b = 8'h80; nxt_addr = S_DOUT; end
      OP_ERASE: begin cmd1_b = 8'h60; cmd2_b = 8'hD0; addr_first = 12'd2; end
      OP_ID:    begin cmd1_b = 8'h90; nxt_addr = S_DIN; addr_last = 12'd0; din_last = 12'd4; end
      OP_RST:   begin cmd1_b = 8'hFF; nxt_cmd1 = S_WAIT; end
      OP_STAT:  begin cmd1_b = 8'h70; nxt_cmd1 = S_DIN; din_last = 12'd0; end
      OP_RRD:   begin cmd1_b = 8'h05; cmd2_b = 8'hE0; addr_last = 12'd1; nxt_cmd2 = S_DIN; end
      default:  begin cmd1_b = 8'h85; nxt_addr = S_DOUT; addr_last = 12'd1; end
    endcase
    case (cnt[1:0])
      2'd0: addr_b = col[7:0];
      2'd1: addr_b = {4'h0, col[11:8]};
      2'd2: addr_b = row[7:0];
      default: addr_b = row[15:8];
    endcase
    if (op == OP_ID) addr_b = 8'h00;
  end

  assign nf_cle   = st == S_CMD1 || st == S_CMD2 || st == S_STCMD;
  assign nf_ale   = st == S_ADDR;
  assign nf_io_oe = nf_cle || nf_ale || st == S_DOUT;
  assign nf_we_n  = !(ph == 2'd1 && nf_io_oe);
  assign nf_re_n  = !(ph == 2'd1 && (st == S_DIN || st == S_STRD));
  assign nf_ce_n  = st == S_IDLE || st == S_FIN;
  assign nf_io_out = st == S_CMD1 ? cmd1_b : st == S_CMD2 ? cmd2_b : st == S_STCMD ? 8'h70 :
                     st == S_ADDR ? addr_b : st == S_DOUT ? dbyte : 8'h00;
  assign req_ready = st == S_IDLE;
  assign wr_ready  = st == S_DOUT && ph == 2'd0;
  assign done      = st == S_FIN;
  assign go        = ph != 2'd0 || (st == S_DOUT ? wr_valid : st == S_DIN ? !rd_valid : 1'b1);
  assign clr_seen  = ph == 2'd1 && ((st == S_CMD2 && op == OP_READ) || (st == S_CMD1 && op == OP_RST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 2'd0; op <= 3'd0; row <= '0; col <= '0; len <= '0; cnt <= '0;
      tmo <= '0; dbyte <= '0; rd_data <= '0; rd_valid <= 1'b0; fail <= 1'b0;
      rb_q <= 1'b1; rb_seen <= 1'b0; st_rdy <= 1'b0; st_bad <= 1'b0;
    end else begin
      rb_q    <= nf_rb;
      rb_seen <= clr_seen ? 1'b0 : (rb_seen | (nf_rb & ~rb_q));
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op <= req_op; row <= req_row; col <= req_col; len <= req_len;
          fail <= 1'b0; ph <= 2'd0; st <= S_CMD1;
        end
        S_WAIT: begin
          tmo <= tmo + 1'b1;
          if (rb_seen) begin st <= (op == OP_RST) ? S_FIN : S_DIN; cnt <= '0; end
          else if (tmo >= TMO_LAST) begin fail <= 1'b1; st <= S_FIN; end
        end
        S_FIN: st <= S_IDLE;
        default: begin
          if (st == S_STRD) tmo <= tmo + 1'b1;
          if (ph == 2'd0) begin
            if (go) ph <= 2'd1;
            if (st == S_DOUT) dbyte <= wr_data;
          end else if (ph == 2'd1) begin
            ph <= 2'd2;
            if (st == S_DIN) begin rd_data <= nf_io_in; rd_valid <= 1'b1; end
            if (st == S_STRD) begin st_rdy <= nf_io_in[6]; st_bad <= nf_io_in[0]; end
          end else begin
            ph <= 2'd0;
            case (st)
              S_CMD1: begin st <= nxt_cmd1; cnt <= addr_first; tmo <= '0; end
              S_ADDR: if (cnt == addr_last) begin st <= nxt_addr; cnt <= '0; end
                      else cnt <= cnt + 1'b1;
              S_DOUT: if (cnt == len) st <= S_CMD2; else cnt <= cnt + 1'b1;
              S_CMD2: begin st <= nxt_cmd2; cnt <= '0; tmo <= '0; end
              S_DIN:  if (cnt == din_last) st <= S_FIN; else cnt <= cnt + 1'b1;
              S_STCMD: begin st <= S_STRD; tmo <= '0; end
              S_STRD: if (st_rdy) begin fail <= st_bad; st <= S_FIN; end
                      else if (tmo >= TMO_LAST) begin fail <= 1'b1; st <= S_FIN; end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R1
  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R12
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT |-> tmo < TW'(TMO_CYCLES)); // R10
  AST_ACCEPT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !nf_ce_n); // R1
endmodule

// File: tb/nand_page_seq_tb.sv
module nand_page_seq_tb;
  localparam int TMO = 200;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0, req_ready, wr_valid = 1'b1, wr_ready, rd_valid;
  logic rd_ready = 1'b1, done, fail, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
  logic nf_rb = 1'b1;
  logic [2:0] req_op = '0;
  logic [15:0] req_row = '0;
  logic [11:0] req_col = '0, req_len = '0;
  logic [7:0] wr_data, rd_data, nf_io_out, nf_io_in = '0, tx_base = 8'h90;
  int wr_idx = 0;
  assign wr_data = tx_base + 8'(wr_idx);

  nand_page_seq #(.TMO_CYCLES(TMO)) u_dut (.*);

  int checks = 0, errors = 0, ncyc = 0, t_cmd = 0, t_done = 0;
  logic [9:0] lg [0:63];
  logic [9:0] ex [0:63];
  logic [7:0] rx [0:63];
  int lg_n = 0, ex_n = 0, rx_n = 0;
  int busy_cnt = 0, busy_len = 20, mode = 0, k = 0, polls = 0, sreads = 0, re_busy = 0;
  logic busy_forever = 1'b0, sfail = 1'b0, we_q = 1'b1, both_hi = 1'b0;
  logic [7:0] id_b [0:4];
  initial begin id_b[0]=8'hEC; id_b[1]=8'hF1; id_b[2]=8'h00; id_b[3]=8'h95; id_b[4]=8'h40; end

  always @(posedge clk) begin
    if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
    if (rd_valid && rd_ready) begin rx[rx_n] <= rd_data; rx_n <= rx_n + 1; end
  end

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (nf_cle && nf_ale) both_hi = 1'b1;
    if (done) t_done = ncyc;
    if (busy_cnt > 0) begin busy_cnt = busy_cnt - 1; if (busy_cnt == 0) nf_rb = 1'b1; end
    if (!nf_re_n) begin
      if (!nf_rb) re_busy = re_busy + 1;
      if (mode == 0) begin nf_io_in = 8'h20 + 8'(k); k = k + 1; end
      else if (mode == 1) begin nf_io_in = id_b[k % 5]; k = k + 1; end
      else begin
        sreads = sreads + 1;
        if (polls > 0) begin polls = polls - 1; nf_io_in = 8'h00; end
        else nf_io_in = {1'b0, 1'b1, 5'b0, sfail};
      end
    end
    if (!we_q && nf_we_n && !nf_ce_n) begin
      lg[lg_n] = {nf_cle, nf_ale, nf_io_out}; lg_n = lg_n + 1;
      if (nf_cle) begin
        case (nf_io_out)
          8'h30, 8'hFF: begin
            t_cmd = ncyc; nf_rb = 1'b0; mode = 0; k = 0;
            busy_cnt = busy_forever ? 0 : busy_len;
          end
          8'hE0: begin mode = 0; k = 0; end
          8'h90: begin mode = 1; k = 0; end
          8'h70: mode = 2;
          default: ;
        endcase
      end
    end
    we_q = nf_we_n;
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic add(input logic c, input logic a, input logic [7:0] b);
    ex[ex_n] = {c, a, b}; ex_n = ex_n + 1;
  endtask

  task automatic cmp_log(input string r);
    int bad = 0;
    for (int i = 0; i < ex_n; i++) if (lg[i] != ex[i]) bad = bad + 1;
    chk(r, "bus cycle count", lg_n, ex_n);
    chk(r, "bus cycle mismatches", bad, 0);
  endtask

  task automatic start_op(input logic [2:0] o, input logic [15:0] r, input logic [11:0] c, input logic [11:0] l);
    @(negedge clk);
    lg_n = 0; ex_n = 0; rx_n = 0; wr_idx = 0; re_busy = 0; sreads = 0;
    req_op = o; req_row = r; req_col = c; req_len = l; req_valid = 1'b1;
    chk("R1", "req_ready while idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "CE# low after accept", nf_ce_n, 0);
    chk("R1", "req_ready low while busy", req_ready, 0);
  endtask

  task automatic wait_done(output logic res);
    int ce_bad = 0;
    int n = 0;
    while (!done && n < 20000) begin
      if (nf_ce_n) ce_bad = ce_bad + 1;
      @(negedge clk); n = n + 1;
    end
    chk("R1", "CE# high inside operation", ce_bad, 0);
    chk("R11", "done seen", done, 1);
    chk("R1", "CE# high at done", nf_ce_n, 1);
    res = fail;
    @(negedge clk);
    chk("R11", "done one cycle", done, 0);
  endtask

  task automatic t_reset_state;
    chk("R1", "reset CE#", nf_ce_n, 1);
    chk("R1", "reset req_ready", req_ready, 1);
    chk("R11", "reset done", done, 0);
    chk("R1", "reset WE#/RE#", {nf_we_n, nf_re_n}, 2'b11);
  endtask

  task automatic t_read_stale;
    logic res;
    @(negedge clk); nf_rb = 1'b0;
    repeat (3) @(negedge clk);
    nf_rb = 1'b1;
    repeat (2) @(negedge clk);
    start_op(3'd0, 16'h1234, 12'h5A7, 12'd3);
    wait_done(res);
    add(1,0,8'h00); add(0,1,8'hA7); add(0,1,8'h05); add(0,1,8'h34); add(0,1,8'h12); add(1,0,8'h30);
    cmp_log("R2");
    chk("R9", "read strobes while busy", re_busy, 0);
    chk("R3", "bytes read", rx_n, 4);
    for (int i = 0; i < 4; i++) chk("R3", "read byte", rx[i], 8'h20 + i);
    chk("R3", "read result", res, 0);
  endtask

  task automatic t_prog(input logic bad);
    logic res;
    polls = 2; sfail = bad;
    start_op(3'd1, 16'h0102, 12'h000, 12'd2);
    wait_done(res);
    add(1,0,8'h80); add(0,1,8'h00); add(0,1,8'h00); add(0,1,8'h02); add(0,1,8'h01);
    for (int i = 0; i < 3; i++) add(0,0,8'h90 + 8'(i));
    add(1,0,8'h10); add(1,0,8'h70);
    cmp_log("R4");
    chk("R4", "status reads", sreads, 3);
    chk("R4", "program result", res, bad);
    sfail = 1'b0;
  endtask

  task automatic t_erase;
    logic res;
    polls = 0;
    start_op(3'd2, 16'hBEEF, 12'h3FF, 12'd0);
    wait_done(res);
    add(1,0,8'h60); add(0,1,8'hEF); add(0,1,8'hBE); add(1,0,8'hD0); add(1,0,8'h70);
    cmp_log("R5");
    chk("R5", "erase result", res, 0);
  endtask

  task automatic t_id;
    logic res;
    start_op(3'd3, 16'hFFFF, 12'hFFF, 12'd9);
    wait_done(res);
    add(1,0,8'h90); add(0,1,8'h00);
    cmp_log("R6");
    chk("R6", "id bytes", rx_n, 5);
    for (int i = 0; i < 5; i++) chk("R6", "id byte", rx[i], id_b[i]);
  endtask

  task automatic t_rst_stat;
    logic res;
    start_op(3'd4, 16'h0, 12'h0, 12'd0);
    wait_done(res);
    add(1,0,8'hFF);
    cmp_log("R7");
    chk("R7", "reset result", res, 0);
    chk("R7", "reset waited for R/B#", nf_rb, 1);
    polls = 0;
    start_op(3'd5, 16'h0, 12'h0, 12'd7);
    wait_done(res);
    ex_n = 0; add(1,0,8'h70);
    cmp_log("R7");
    chk("R7", "status byte count", rx_n, 1);
    chk("R7", "status byte", rx[0], 8'h40);
  endtask

  task automatic t_random;
    logic res;
    start_op(3'd6, 16'h7777, 12'h801, 12'd1);
    wait_done(res);
    add(1,0,8'h05); add(0,1,8'h01); add(0,1,8'h08); add(1,0,8'hE0);
    cmp_log("R8");
    chk("R8", "random read bytes", rx_n, 2);
    chk("R8", "random read byte", rx[1], 8'h21);
    polls = 1;
    start_op(3'd7, 16'h7777, 12'h123, 12'd0);
    wait_done(res);
    ex_n = 0;
    add(1,0,8'h85); add(0,1,8'h23); add(0,1,8'h01); add(0,0,8'h90); add(1,0,8'h10); add(1,0,8'h70);
    cmp_log("R8");
    chk("R8", "random input result", res, 0);
  endtask

  task automatic t_timeout;
    logic res;
    busy_forever = 1'b1;
    start_op(3'd0, 16'h0042, 12'h000, 12'd0);
    wait_done(res);
    chk("R10", "timeout result", res, 1);
    chk("R10", "cycles to done", t_done - t_cmd, TMO + 1);
    chk("R10", "no read strobe", re_busy, 0);
    busy_forever = 1'b0;
    nf_rb = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_backpressure;
    logic res;
    logic [7:0] d0;
    int held_bad = 0;
    int n = 0;
    rd_ready = 1'b0;
    start_op(3'd0, 16'h0005, 12'h000, 12'd3);
    while (!rd_valid && n < 5000) begin @(negedge clk); n = n + 1; end
    d0 = rd_data;
    repeat (6) begin
      @(negedge clk);
      if (!rd_valid || rd_data != d0) held_bad = held_bad + 1;
    end
    chk("R12", "held under backpressure", held_bad, 0);
    chk("R12", "first byte", d0, 8'h20);
    rd_ready = 1'b1;
    wait_done(res);
    chk("R12", "bytes after release", rx_n, 4);
    chk("R12", "last byte", rx[3], 8'h23);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read_stale();
    t_prog(1'b0);
    t_prog(1'b1);
    t_erase();
    t_id();
    t_rst_stat();
    t_random();
    t_timeout();
    t_backpressure();
    chk("R11", "CLE and ALE together", both_hi, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors = errors + 1;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule